// File: doc/BRIEF.md
# Line-Tagged Shared Receive Buffer

This block is the receive half of a multi-line serial multiplexer. Each line has its own receiver that has already turned the serial stream into a character plus framing and parity flags. The block applies the line's settings (receiver on or off, character width), holds each arriving character in a one-deep staging slot per line, and moves staged characters one per cycle into a single queue shared by all lines. Every queue entry carries the source line number and its error flags, so software learns everything about a character from one 16-bit word.

Software works through a small register bus. Reading the buffer word pops the oldest entry; a clear valid bit in the returned word tells the reader that the queue is drained. A write to the same address sets the parameters of the line named in the written word. A control word holds the interrupt enable and shows whether data is waiting, and the interrupt output is raised while both are true. Baud generation and the transmit path are outside the block; the per-line settings are driven out to the receivers.

Top module: `lsrb_top`

## Requirements
- R1: After reset the interrupt enable is clear, the queue and every staging slot are empty, every line's settings read as zero (receiver off), irq is low, and both register addresses read 0x0000.
- R2: A buffer word read at address 1 is laid out as: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:8 source line number, bits 7:0 character; bits of a valid word not listed here do not exist (the line field is 4 bits wide).
- R3: Each read of address 1 with bus_rd high returns the oldest queued entry and removes it, so entries leave in the order they entered; the queue holds DEPTH entries.
- R4: A read of address 1 while the queue is empty returns 0x0000 and changes no state: a character sent afterwards is the next and only entry read.
- R5: A write to address 1 sets the settings of line bits 3:0 only, from: size code bits 5:4, two-stop flag bit 6, parity-enable bit 7, odd-parity bit 8, baud code bits 12:9, receiver enable bit 13. The line's settings appear on line_cfg bits [10*i +: 10] as {enable, baud[3:0], odd, parity, two_stop, size[1:0]} (bit 9 down to 0). Writes naming a line at or above LINES change nothing.
- R6: Baud codes 0 to 14 select 50, 75, 110, 134, 150, 300, 600, 1200, 1800, 2000, 2400, 3600, 4800, 7200 and 9600 baud in that order; a write carrying code 15 keeps the line's previous baud code while the other fields are updated.
- R7: A character arriving on a line whose receiver enable is clear is discarded and never reaches the queue.
- R8: Size code k keeps the low 5+k bits of the character; the upper bits of the stored character are zero.
- R9: The framing and parity flags from the line's receiver are stored with the character; a break arrives as character 0x00 with the framing flag and is stored that way.
- R10: A character presented in clock cycle k sits in its staging slot after edge k and is readable after edge k+1 if no other line is ahead of it; characters arriving together enter the queue lowest line first, one per cycle.
- R11: While the queue is full the staged character waits; a further character arriving on a line whose slot is occupied and not leaving is discarded and the overrun bit of the occupying character is set.
- R12: Address 0 reads interrupt enable in bit 0 (written through bit 0) and queue-not-empty in bit 1; irq is high exactly when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address (0 control, 1 buffer/parameters) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the queue at address 1 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| line_valid | input | LINES | Per-line character-ready strobe from the receivers |
| line_char | input | LINES*8 | Per-line received character |
| line_ferr | input | LINES | Per-line framing error flag |
| line_perr | input | LINES | Per-line parity error flag |
| line_cfg | output | LINES*10 | Per-line settings driven to the receivers |
| irq | output | 1 | Receive interrupt |

## Verification
The bench builds the block with four lines and a four-entry queue, so the full-queue wait, the staging-slot drop and the overrun marking are reached after only a handful of characters. With four lines every line can be made to send in the same cycle, which puts the lowest-first drain order under test, and the small width set lets the bench sweep every size code across a spread of characters and every baud code on one line while watching the other lines' settings hold.

// File: rtl/lsrb_pkg.sv
package lsrb_pkg;

  localparam int CHW  = 8;
  localparam int LNW  = 4;
  localparam int WORDW = 16;

  typedef struct packed {
    logic       en;
    logic [3:0] baud;
    logic       odd;
    logic       par;
    logic       stop2;
    logic [1:0] size;
  } line_cfg_t;

  typedef struct packed {
    logic           ovr;
    logic           ferr;
    logic           perr;
    logic [LNW-1:0] line;
    logic [CHW-1:0] ch;
  } entry_t;

  localparam int CFGW = $bits(line_cfg_t);
  localparam int ENTW = $bits(entry_t);

  // keep the low 5+code bits of a character
  function automatic logic [CHW-1:0] size_mask(input logic [1:0] code);
    return 8'hFF >> (2'd3 - code);
  endfunction

  function automatic logic [WORDW-1:0] pack_word(input entry_t e);
    return {1'b1, e.ovr, e.ferr, e.perr, e.line, e.ch};
  endfunction

  function automatic line_cfg_t cfg_from_word(input logic [WORDW-1:0] w,
                                              input line_cfg_t old);
    line_cfg_t c;
    c.size  = w[5:4];
    c.stop2 = w[6];
    c.par   = w[7];
    c.odd   = w[8];
    c.baud  = (w[12:9] == 4'd15) ? old.baud : w[12:9];
    c.en    = w[13];
    return c;
  endfunction

endpackage

// File: rtl/lsrb_stage.sv
module lsrb_stage
  import lsrb_pkg::*;
#(
  parameter int LINE_ID = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  line_cfg_t      cfg,
  input  logic           in_valid,
  input  logic [CHW-1:0] in_ch,
  input  logic           in_ferr,
  input  logic           in_perr,
  input  logic           grant,
  output logic           req,
  output entry_t         ent
);

  logic   full;
  entry_t slot;

  logic take, leave, accept, drop;
  assign take   = in_valid & cfg.en;
  assign leave  = full & grant;
  assign accept = take & (~full | leave);
  assign drop   = take & full & ~leave;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      slot <= '0;
    end else if (accept) begin
      full      <= 1'b1;
      slot.ovr  <= 1'b0;
      slot.ferr <= in_ferr;
      slot.perr <= in_perr;
      slot.line <= LNW'(LINE_ID);
      slot.ch   <= in_ch & size_mask(cfg.size);
    end else begin
      if (leave) full <= 1'b0;
      if (drop)  slot.ovr <= 1'b1;
    end
  end

  assign req = full;
  assign ent = slot;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !grant) |=> full);
  p_drop_marks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (full && slot.ovr));
  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg.en && !full) |=> !full);
  p_no_grant_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> full);

endmodule

// File: rtl/lsrb_arb.sv
module lsrb_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         ready,
  output logic [N-1:0] grant
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (ready && req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  p_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req[0]) |-> grant[0]);

endmodule

// File: rtl/lsrb_fifo.sv
module lsrb_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout = mem[rp];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !full) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lsrb_top.sv
module lsrb_top
  import lsrb_pkg::*;
#(
  parameter int LINES = 4,
  parameter int DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [LINES-1:0]      line_valid,
  input  logic [LINES*CHW-1:0]  line_char,
  input  logic [LINES-1:0]      line_ferr,
  input  logic [LINES-1:0]      line_perr,
  output logic [LINES*CFGW-1:0] line_cfg,
  output logic                  irq
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_BUF  = 2'd1;

  logic      ie_q;
  line_cfg_t cfg_q [LINES];

  logic [LINES-1:0] req, grant;
  entry_t           ent [LINES];
  entry_t           push_ent, head;
  logic             q_empty, q_full, push, pop;

  logic wr_ctrl, wr_param;
  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign wr_param = bus_wr & (bus_addr == A_BUF) &
                    ({1'b0, bus_wdata[3:0]} < 5'(LINES));
  assign pop      = bus_rd & (bus_addr == A_BUF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
      for (int i = 0; i < LINES; i++) cfg_q[i] <= '0;
    end else begin
      if (wr_ctrl) ie_q <= bus_wdata[0];
      for (int i = 0; i < LINES; i++)
        if (wr_param && (bus_wdata[3:0] == LNW'(i)))
          cfg_q[i] <= cfg_from_word(bus_wdata, cfg_q[i]);
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lsrb_stage #(.LINE_ID(g)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_q[g]),
      .in_valid (line_valid[g]),
      .in_ch    (line_char[g*CHW +: CHW]),
      .in_ferr  (line_ferr[g]),
      .in_perr  (line_perr[g]),
      .grant    (grant[g]),
      .req      (req[g]),
      .ent      (ent[g])
    );
    assign line_cfg[g*CFGW +: CFGW] = cfg_q[g];

    p_cfg_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_param && bus_wdata[3:0] != LNW'(g)) |=> $stable(cfg_q[g]));
  end

  lsrb_arb #(.N(LINES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .ready (~q_full),
    .grant (grant)
  );

  always_comb begin
    push_ent = '0;
    for (int i = 0; i < LINES; i++)
      if (grant[i]) push_ent = push_ent | ent[i];
  end
  assign push = |grant;

  lsrb_fifo #(.DEPTH(DEPTH), .W(ENTW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_ent),
    .pop   (pop),
    .dout  (head),
    .empty (q_empty),
    .full  (q_full)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {14'd0, ~q_empty, ie_q};
      A_BUF:   bus_rdata = q_empty ? 16'h0000 : pack_word(head);
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq = ie_q & ~q_empty;

  p_irq_needs_ie_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ie_q && ($past(wr_ctrl) || $past(push))));
  p_fifo_fed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && q_empty) |=> !q_empty);

endmodule

// File: tb/sim_lsrb_top.sv
module sim_lsrb_top;

  localparam int L = 4;
  localparam int D = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic [L-1:0]  line_valid = '0;
  logic [L*8-1:0] line_char = '0;
  logic [L-1:0]  line_ferr = '0, line_perr = '0;
  logic [L*10-1:0] line_cfg;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lsrb_top #(.LINES(L), .DEPTH(D)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic send(input int ln, input logic [7:0] c, input logic fe, input logic pe);
    @(negedge clk);
    line_valid[ln] = 1'b1; line_char[ln*8 +: 8] = c; line_ferr[ln] = fe; line_perr[ln] = pe;
    @(negedge clk);
    line_valid = '0; line_ferr = '0; line_perr = '0;
  endtask

  function automatic logic [15:0] pword(int ln, int sz, int stop, int par, int odd, int baud, int en);
    return 16'(ln + (sz << 4) + (stop << 6) + (par << 7) + (odd << 8) + (baud << 9) + (en << 13));
  endfunction

  function automatic logic [9:0] ecfg(int sz, int stop, int par, int odd, int baud, int en);
    return 10'(sz + (stop << 2) + (par << 3) + (odd << 4) + (baud << 5) + (en << 9));
  endfunction

  function automatic logic [15:0] eword(int ln, logic [7:0] c, int sz, int ovr, int fe, int pe);
    logic [7:0] m;
    m = 8'((1 << (5 + sz)) - 1);
    return 16'(32768 + (ovr << 14) + (fe << 13) + (pe << 12) + (ln << 8) + (c & m));
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [39:0] cfg_before;
    wait_n(3); rst_n = 1'b1; wait_n(1);

    // R1 reset state
    bus_read(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    chk("R1 irq", irq, 0);
    chk("R1 cfg", line_cfg, 0);
    bus_read(2'd1, v); chk("R1 buf", v, 16'h0000);

    // R7 receiver off discards
    send(0, 8'h55, 0, 0); wait_n(3);
    bus_read(2'd1, v); chk("R7 disabled line", v, 16'h0000);
    bus_read(2'd0, v); chk("R7 no data", v, 16'h0000);

    // R5 R6 baud sweep on line 2, others stable
    for (int b = 0; b < 15; b++) begin
      bus_write(2'd1, pword(2, b % 4, b % 2, (b / 2) % 2, (b / 4) % 2, b, 0));
      wait_n(1);
      chk("R6 baud code", line_cfg[20 +: 10], ecfg(b % 4, b % 2, (b / 2) % 2, (b / 4) % 2, b, 0));
      chk("R5 other lines", {line_cfg[30 +: 10], line_cfg[0 +: 20]}, 30'd0);
    end
    bus_write(2'd1, pword(2, 1, 0, 1, 1, 15, 1)); wait_n(1);
    chk("R6 code 15 keeps", line_cfg[20 +: 10], ecfg(1, 0, 1, 1, 14, 1));
    cfg_before = line_cfg;
    bus_write(2'd1, 16'h000F | pword(0, 3, 1, 1, 1, 3, 1)); wait_n(1);
    chk("R5 out-of-range line", line_cfg, cfg_before);

    for (int i = 0; i < L; i++) bus_write(2'd1, pword(i, 3, 0, 0, 0, 14, 1));
    wait_n(1);
    for (int i = 0; i < L; i++)
      chk("R5 all lines set", line_cfg[i*10 +: 10], ecfg(3, 0, 0, 0, 14, 1));

    // R10 R2 simultaneous arrival, latency and order
    @(negedge clk);
    for (int i = 0; i < L; i++) line_char[i*8 +: 8] = 8'(8'hA0 + i);
    line_valid = '1;
    @(negedge clk); line_valid = '0;
    #1 chk("R10 staged not yet readable", bus_rdata === 16'h0 || bus_addr != 2'd1, 1);
    bus_addr = 2'd0; #1 chk("R10 not ready after edge k", bus_rdata[1], 0);
    @(negedge clk); #1 chk("R10 ready after edge k+1", bus_rdata[1], 1);
    wait_n(4);
    for (int i = 0; i < L; i++) begin
      bus_read(2'd1, v); chk("R10 R2 lowest line first", v, eword(i, 8'(8'hA0 + i), 3, 0, 0, 0));
    end

    // R8 size sweep
    for (int sz = 0; sz < 4; sz++) begin
      bus_write(2'd1, pword(1, sz, 0, 0, 0, 5, 1));
      for (int c = 3; c < 256; c += 28) begin
        send(1, 8'(c), 0, 0); wait_n(2);
        bus_read(2'd1, v); chk("R8 size mask", v, eword(1, 8'(c), sz, 0, 0, 0));
      end
    end

    // R9 break and error flags
    send(3, 8'h00, 1, 0); wait_n(2);
    bus_read(2'd1, v); chk("R9 break", v, 16'hA300);
    send(3, 8'h7E, 0, 1); wait_n(2);
    bus_read(2'd1, v); chk("R9 parity", v, eword(3, 8'h7E, 3, 0, 0, 1));
    send(3, 8'h81, 1, 1); wait_n(2);
    bus_read(2'd1, v); chk("R9 both flags", v, eword(3, 8'h81, 3, 0, 1, 1));

    // R3 R11 fill, wait, drop and overrun
    for (int i = 0; i < D; i++) begin send(0, 8'(8'h10 + i), 0, 0); wait_n(2); end
    send(0, 8'h20, 0, 0); wait_n(2);
    send(0, 8'h21, 0, 0); wait_n(2);
    for (int i = 0; i < D; i++) begin
      bus_read(2'd1, v); chk("R3 fifo order", v, eword(0, 8'(8'h10 + i), 3, 0, 0, 0));
    end
    bus_read(2'd1, v); chk("R11 overrun on staged", v, eword(0, 8'h20, 3, 1, 0, 0));
    bus_read(2'd1, v); chk("R11 dropped char absent", v, 16'h0000);

    // R4 empty read has no side effect
    bus_read(2'd1, v); chk("R4 empty read", v, 16'h0000);
    send(2, 8'h3C, 0, 0); wait_n(2);
    bus_read(2'd1, v); chk("R4 next entry", v, eword(2, 8'h3C, 3, 0, 0, 0));
    bus_read(2'd1, v); chk("R4 only entry", v, 16'h0000);

    // R12 interrupt
    bus_write(2'd0, 16'h0001); wait_n(1);
    chk("R12 no data no irq", irq, 0);
    bus_read(2'd0, v); chk("R12 ctrl ie", v, 16'h0001);
    send(1, 8'h44, 0, 0); wait_n(2);
    chk("R12 irq raised", irq, 1);
    bus_read(2'd0, v); chk("R12 ctrl both", v, 16'h0003);
    bus_write(2'd0, 16'h0000); wait_n(1);
    chk("R12 ie off", irq, 0);
    bus_write(2'd0, 16'h0001); wait_n(1);
    chk("R12 ie back on", irq, 1);
    bus_read(2'd1, v); wait_n(1);
    chk("R12 drained", irq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule